// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the DMA-side control engine for a transmit path. It walks a ring of transmit descriptors kept in a synchronous memory. Each descriptor is four 32-bit words. Word 0 holds control and status, word 1 holds the buffer length and word 2 holds the buffer address. Word 3 is not read.

For every descriptor, the engine first checks who owns it. If the DMA owns it, the engine reads the length and the buffer address and hands a segment request to a downstream frame mover. It then waits for that mover to report the segment done. Next it writes word 0 back with ownership returned to the CPU. First and last markers group consecutive descriptors into frames. Frame controls are taken from the opening descriptor of each frame. A completion interrupt is raised when the closing descriptor asks for it.

When the engine meets a descriptor the CPU still owns, it parks in a suspended state. Software wakes it with a poll-demand pulse. Ring wrap is driven by a flag in the descriptor, not by a count.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset the block is suspended, `tx_irq` is 0 and no memory access or segment request is issued. It starts fetching only on a `poll_demand` pulse, from `ring_base`.
- R2: If word 0 of a fetched descriptor has bit 31 = 0 (CPU owned), the block returns to suspended without writing memory or requesting a segment. The next `poll_demand` refetches that same descriptor address.
- R3: For a DMA-owned descriptor, `seg_req` is raised with `seg_addr` = word 2, `seg_len` = word 1 bits 12:0, `seg_first` = word 0 bit 28 and `seg_last` = word 0 bit 29. All of these hold steady until `seg_done` is seen.
- R4: After `seg_done`, word 0 is written back to the descriptor's own address with bit 31 cleared and every other bit unchanged.
- R5: The next descriptor lies 16 bytes after the current one, unless the current one has bit 21 set. In that case the next fetch is at `ring_base`.
- R6: `seg_ctrl` = {bit 25, bits 23:22, bit 26, bit 27} of word 0. It is taken only from the descriptor with bit 28 set and is kept unchanged for the later descriptors of that frame, whatever their own bits hold.
- R7: A completed descriptor with bit 29 and bit 30 both set raises `tx_irq` at its write-back. `tx_irq` stays high until an `irq_clr` pulse. If a raise and `irq_clr` fall in the same cycle, the raise wins.
- R8: A descriptor that lacks bit 28 while no frame is open issues no segment request. It is written back with bit 31 cleared and bit 15 set, and `err_pulse` is high during that write. The walk then carries on with the next descriptor, which may open a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Byte address of the first descriptor of the ring |
| poll_demand | input | 1 | Wake pulse while suspended |
| mem_rd | output | 1 | Descriptor memory read strobe; data is returned next cycle |
| mem_we | output | 1 | Descriptor memory write strobe |
| mem_addr | output | AW | Byte address for read or write |
| mem_wdata | output | 32 | Write-back word |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| seg_req | output | 1 | Segment request to the frame mover |
| seg_addr | output | 32 | Buffer address of the segment |
| seg_len | output | LW | Buffer length in bytes |
| seg_first | output | 1 | Segment opens a frame |
| seg_last | output | 1 | Segment closes a frame |
| seg_ctrl | output | 5 | Frame controls {time stamp, checksum[1:0], no pad, no CRC} |
| seg_done | input | 1 | Frame mover has finished the requested segment |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| tx_irq | output | 1 | Sticky transmit-complete interrupt |
| suspended | output | 1 | Engine is parked waiting for `poll_demand` |
| err_pulse | output | 1 | High during the write-back of a stray descriptor |

## Verification
The clash of interest is a completion interrupt being raised by a write-back in the same cycle that software clears the flag. To provoke it, two back-to-back interrupting frames are run. The first frame sets the flag. `irq_clr` is then driven high exactly while the second frame's write-back strobe is visible on the memory port. The flag must still read 1 after that edge, and a later lone clear must bring it to 0.

// File: rtl/tw_pkg.sv
// Shared constants and types for the transmit descriptor ring walker.
// Assumes a 32-bit descriptor control word; bit positions below are the
// layout the CPU-side driver decodes, so they are fixed, not parameters.
package tw_pkg;
    localparam int OWN_B    = 31;
    localparam int IRQ_B    = 30;
    localparam int LAST_B   = 29;
    localparam int FIRST_B  = 28;
    localparam int NOCRC_B  = 27;
    localparam int NOPAD_B  = 26;
    localparam int TSTAMP_B = 25;
    localparam int CSUM_HI  = 23;
    localparam int CSUM_LO  = 22;
    localparam int WRAP_B   = 21;
    localparam int ERRS_B   = 15;

    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 16;

    typedef enum logic [2:0] {
        ST_SUSP,
        ST_FETCH,
        ST_CTRL,
        ST_LEN,
        ST_BUF,
        ST_MOVE,
        ST_WBACK
    } walk_st_t;

    typedef struct packed {
        logic       tstamp;
        logic [1:0] csum;
        logic       no_pad;
        logic       no_crc;
    } frame_ctrl_t;
endpackage

// File: rtl/tw_ring_addr.sv
// Current-descriptor address register.
// Loads the ring base in reset, then on each advance either steps one
// descriptor forward or returns to the base when the wrap flag is set.
// Assumes ring_base is stable while the block is out of reset.
module tw_ring_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    import tw_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    // Hold or move the descriptor pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= base;
        end else if (adv) begin
            cur <= wrap ? base : cur + STEP;
        end
    end
endmodule

// File: rtl/tw_frame_track.sv
// Frame grouping state.
// Tracks whether a frame is open, flags descriptors that continue or close
// a frame that was never opened, and latches the per-frame controls from
// the opening descriptor only.
// Assumes is_first/is_last/ctrl_in come from the captured control word.
module tw_frame_track (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                is_first,
    input  logic                is_last,
    input  tw_pkg::frame_ctrl_t ctrl_in,
    input  logic                load,
    input  logic                close,
    output logic                orphan,
    output tw_pkg::frame_ctrl_t ctrl_q
);
    logic in_frame;

    assign orphan = !in_frame && !is_first;

    // Open on a first segment, close on a last segment; strays leave it shut.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
        end else if (close && !orphan) begin
            in_frame <= !is_last;
        end
    end

    // Capture frame controls only from the opening descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (load && is_first) begin
            ctrl_q <= ctrl_in;
        end
    end
endmodule

// File: rtl/tw_irq_flag.sv
// Sticky interrupt flag with write-one-to-clear.
// A set request takes priority over a clear in the same cycle so that no
// completion is lost.
module tw_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_ring_walker.sv
// Transmit descriptor ring walker (top).
// Walks four-word descriptors in a synchronous memory (read data returns the
// cycle after mem_rd), requests one segment per owned descriptor, writes the
// control word back with ownership released, and raises a sticky interrupt.
// Assumes the frame mover holds seg_done for one cycle per request.
module tx_ring_walker #(
    parameter int AW = 16,
    parameter int LW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          poll_demand,
    output logic          mem_rd,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          seg_req,
    output logic [31:0]   seg_addr,
    output logic [LW-1:0] seg_len,
    output logic          seg_first,
    output logic          seg_last,
    output logic [4:0]    seg_ctrl,
    input  logic          seg_done,
    input  logic          irq_clr,
    output logic          tx_irq,
    output logic          suspended,
    output logic          err_pulse
);
    import tw_pkg::*;

    localparam logic [AW-1:0] OFS_LEN = AW'(WORD_BYTES);
    localparam logic [AW-1:0] OFS_BUF = AW'(2 * WORD_BYTES);

    walk_st_t    st, st_nx;
    logic [31:0] w0_q;
    logic [31:0] buf_q;
    logic [LW-1:0] len_q;
    logic [AW-1:0] cur;
    logic        orphan;
    logic        owned_now;
    frame_ctrl_t ctrl_in;
    frame_ctrl_t ctrl_q;
    logic        wb_cyc;
    logic [31:0] wb_word;

    assign owned_now = mem_rdata[OWN_B];
    assign wb_cyc    = (st == ST_WBACK);

    // Map the captured control word onto the frame-control fields.
    always_comb begin
        ctrl_in.tstamp = w0_q[TSTAMP_B];
        ctrl_in.csum   = w0_q[CSUM_HI:CSUM_LO];
        ctrl_in.no_pad = w0_q[NOPAD_B];
        ctrl_in.no_crc = w0_q[NOCRC_B];
    end

    tw_ring_addr #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .base  (ring_base),
        .adv   (wb_cyc),
        .wrap  (w0_q[WRAP_B]),
        .cur   (cur)
    );

    tw_frame_track u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_first (w0_q[FIRST_B]),
        .is_last  (w0_q[LAST_B]),
        .ctrl_in  (ctrl_in),
        .load     ((st == ST_LEN) && !orphan),
        .close    (wb_cyc),
        .orphan   (orphan),
        .ctrl_q   (ctrl_q)
    );

    tw_irq_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wb_cyc && !orphan && w0_q[LAST_B] && w0_q[IRQ_B]),
        .clr   (irq_clr),
        .flag  (tx_irq)
    );

    // Walk state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_SUSP;
        end else begin
            st <= st_nx;
        end
    end

    // Next-state decision for the descriptor walk.
    always_comb begin
        st_nx = st;
        case (st)
            ST_SUSP:  if (poll_demand) st_nx = ST_FETCH;
            ST_FETCH: st_nx = ST_CTRL;
            ST_CTRL:  st_nx = owned_now ? ST_LEN : ST_SUSP;
            ST_LEN:   st_nx = orphan ? ST_WBACK : ST_BUF;
            ST_BUF:   st_nx = ST_MOVE;
            ST_MOVE:  if (seg_done) st_nx = ST_WBACK;
            ST_WBACK: st_nx = ST_FETCH;
            default:  st_nx = ST_SUSP;
        endcase
    end

    // Capture descriptor words as they return from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0_q  <= '0;
            len_q <= '0;
            buf_q <= '0;
        end else begin
            if (st == ST_CTRL) w0_q  <= mem_rdata;
            if (st == ST_LEN)  len_q <= mem_rdata[LW-1:0];
            if (st == ST_BUF)  buf_q <= mem_rdata;
        end
    end

    // Memory strobes and address for fetch and write-back.
    always_comb begin
        mem_rd   = (st == ST_FETCH) || ((st == ST_CTRL) && owned_now) ||
                   ((st == ST_LEN) && !orphan);
        mem_we   = wb_cyc;
        case (st)
            ST_CTRL: mem_addr = cur + OFS_LEN;
            ST_LEN:  mem_addr = cur + OFS_BUF;
            default: mem_addr = cur;
        endcase
    end

    // Write-back word: ownership released, error summary on strays.
    always_comb begin
        wb_word         = w0_q;
        wb_word[OWN_B]  = 1'b0;
        if (orphan) wb_word[ERRS_B] = 1'b1;
    end
    assign mem_wdata = wb_word;

    // Segment request and status outputs.
    assign seg_req   = (st == ST_MOVE);
    assign seg_addr  = buf_q;
    assign seg_len   = len_q;
    assign seg_first = w0_q[FIRST_B];
    assign seg_last  = w0_q[LAST_B];
    assign seg_ctrl  = ctrl_q;
    assign suspended = (st == ST_SUSP);
    assign err_pulse = wb_cyc && orphan;
endmodule

// File: rtl/tw_walker_chk.sv
// Protocol checker for tx_ring_walker, attached by bind below.
// Observes only the top-level ports.
module tw_walker_chk #(
    parameter int LW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          poll_demand,
    input logic          mem_rd,
    input logic          mem_we,
    input logic          wb_own,
    input logic          wb_err,
    input logic          seg_req,
    input logic          seg_done,
    input logic [31:0]   seg_addr,
    input logic [LW-1:0] seg_len,
    input logic [4:0]    seg_ctrl,
    input logic          irq_clr,
    input logic          tx_irq,
    input logic          suspended,
    input logic          err_pulse
);
    AST_QUIET_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !mem_rd && !mem_we && !seg_req); // R1
    AST_WAKE_BY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && !poll_demand |=> suspended); // R2
    AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        seg_req && !seg_done |=> seg_req && $stable(seg_addr) && $stable(seg_len) && $stable(seg_ctrl)); // R3
    AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wb_own && !mem_rd && !seg_req); // R4
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq && !irq_clr |=> tx_irq); // R7
    AST_IRQ_AT_WB: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_irq && !mem_we |=> !tx_irq); // R7
    AST_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> mem_we && wb_err); // R8
endmodule

bind tx_ring_walker tw_walker_chk #(.LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_demand (poll_demand),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .wb_own      (mem_wdata[31]),
    .wb_err      (mem_wdata[15]),
    .seg_req     (seg_req),
    .seg_done    (seg_done),
    .seg_addr    (seg_addr),
    .seg_len     (seg_len),
    .seg_ctrl    (seg_ctrl),
    .irq_clr     (irq_clr),
    .tx_irq      (tx_irq),
    .suspended   (suspended),
    .err_pulse   (err_pulse)
);

// File: tb/sim_tx_ring_walker.sv
`timescale 1ns/1ps
module sim_tx_ring_walker;
    localparam int AW = 16;
    localparam int LW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base = 16'h0100;
    logic          poll_demand = 1'b0;
    logic          mem_rd, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          seg_req;
    logic [31:0]   seg_addr;
    logic [LW-1:0] seg_len;
    logic          seg_first, seg_last;
    logic [4:0]    seg_ctrl;
    logic          seg_done = 1'b0;
    logic          irq_clr = 1'b0;
    logic          tx_irq, suspended, err_pulse;

    int total = 0;
    int bad = 0;
    int seg_cnt = 0;
    int err_cnt = 0;
    logic [31:0]   mem [0:255];
    logic [31:0]   lg_addr  [0:15];
    logic [LW-1:0] lg_len   [0:15];
    logic          lg_first [0:15];
    logic          lg_last  [0:15];
    logic [4:0]    lg_ctrl  [0:15];

    always #2 clk = ~clk;

    tx_ring_walker #(.AW(AW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll_demand(poll_demand),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .seg_req(seg_req), .seg_addr(seg_addr), .seg_len(seg_len),
        .seg_first(seg_first), .seg_last(seg_last), .seg_ctrl(seg_ctrl),
        .seg_done(seg_done), .irq_clr(irq_clr), .tx_irq(tx_irq),
        .suspended(suspended), .err_pulse(err_pulse)
    );

    // Synchronous descriptor memory, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // Frame mover model: logs each request, answers two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (seg_req && !seg_done) begin
                if (seg_cnt < 16) begin
                    lg_addr[seg_cnt]  = seg_addr;
                    lg_len[seg_cnt]   = seg_len;
                    lg_first[seg_cnt] = seg_first;
                    lg_last[seg_cnt]  = seg_last;
                    lg_ctrl[seg_cnt]  = seg_ctrl;
                end
                seg_cnt++;
                @(negedge clk);
                @(negedge clk);
                seg_done = 1'b1;
                @(negedge clk);
                seg_done = 1'b0;
            end
        end
    end

    always @(negedge clk) if (rst_n && err_pulse) err_cnt++;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] ln,
                            input logic [31:0] ba);
        mem[a >> 2]       = w0;
        mem[(a >> 2) + 1] = ln;
        mem[(a >> 2) + 2] = ba;
        mem[(a >> 2) + 3] = 32'h0;
    endtask

    task automatic do_reset();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        rst_n = 1'b0;
        poll_demand = 1'b0;
        irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        seg_cnt = 0;
        err_cnt = 0;
        @(negedge clk);
    endtask

    task automatic poll_and_wait(input string req);
        @(negedge clk);
        poll_demand = 1'b1;
        @(negedge clk);
        poll_demand = 1'b0;
        for (int i = 0; i < 1000 && !suspended; i++) @(negedge clk);
        chk(req, "back to suspended", 32'(suspended), 32'd1);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // R1: reset state and idle until poll.
    task automatic t_reset();
        do_reset();
        chk("R1", "suspended", 32'(suspended), 32'd1);
        chk("R1", "irq", 32'(tx_irq), 32'd0);
        chk("R1", "seg_req", 32'(seg_req), 32'd0);
        put_desc(16'h100, 32'hB000_0000, 32'd8, 32'h1111_0000);
        repeat (6) begin
            @(negedge clk);
            chk("R1", "no access without poll", 32'({mem_rd, mem_we}), 32'd0);
        end
        chk("R1", "no segment without poll", 32'(seg_cnt), 32'd0);
        poll_and_wait("R1");
        chk("R1", "first fetch at ring base", lg_addr[0], 32'h1111_0000);
    endtask

    // Single-descriptor frame, owner stop, refetch, irq clear.
    task automatic t_single();
        do_reset();
        put_desc(16'h100, 32'hF080_0040, 32'hFFFF_E123, 32'hCAFE_0010);
        put_desc(16'h110, 32'h3000_0000, 32'd64, 32'hBEEF_0020);
        poll_and_wait("R3");
        chk("R3", "seg count", 32'(seg_cnt), 32'd1);
        chk("R3", "seg addr", lg_addr[0], 32'hCAFE_0010);
        chk("R3", "seg len", 32'(lg_len[0]), 32'h0123);
        chk("R3", "first/last", 32'({lg_first[0], lg_last[0]}), 32'd3);
        chk("R6", "ctrl", 32'(lg_ctrl[0]), 32'b01000);
        chk("R4", "write-back word", mem[64], 32'h7080_0040);
        chk("R2", "cpu-owned untouched", mem[68], 32'h3000_0000);
        chk("R7", "irq raised", 32'(tx_irq), 32'd1);
        poll_and_wait("R2");
        chk("R2", "still no segment", 32'(seg_cnt), 32'd1);
        pulse_clr();
        chk("R7", "irq cleared", 32'(tx_irq), 32'd0);
        mem[68] = 32'hB000_0000;
        poll_and_wait("R2");
        chk("R2", "refetch same addr", lg_addr[1], 32'hBEEF_0020);
        chk("R7", "no irq without request", 32'(tx_irq), 32'd0);
    endtask

    // Three-descriptor frame: controls from the first only.
    task automatic t_multi();
        do_reset();
        put_desc(16'h100, 32'h9E40_0000, 32'd100, 32'hA000_0000);
        put_desc(16'h110, 32'h80C0_0000, 32'd200, 32'hA000_1000);
        put_desc(16'h120, 32'hE000_0000, 32'd300, 32'hA000_2000);
        poll_and_wait("R6");
        chk("R3", "seg count", 32'(seg_cnt), 32'd3);
        for (int k = 0; k < 3; k++)
            chk("R6", "ctrl from opener", 32'(lg_ctrl[k]), 32'b10111);
        chk("R3", "flags 0", 32'({lg_first[0], lg_last[0]}), 32'b10);
        chk("R3", "flags 1", 32'({lg_first[1], lg_last[1]}), 32'b00);
        chk("R3", "flags 2", 32'({lg_first[2], lg_last[2]}), 32'b01);
        chk("R5", "step +16", lg_addr[2], 32'hA000_2000);
        chk("R4", "wb 0", mem[64], 32'h1E40_0000);
        chk("R4", "wb 1", mem[68], 32'h00C0_0000);
        chk("R4", "wb 2", mem[72], 32'h6000_0000);
        chk("R7", "irq at frame end", 32'(tx_irq), 32'd1);
    endtask

    // R5: wrap on the end-of-ring flag.
    task automatic t_ring();
        do_reset();
        put_desc(16'h100, 32'hB000_0000, 32'd16, 32'hD000_0000);
        put_desc(16'h110, 32'hB020_0000, 32'd16, 32'hD000_0100);
        put_desc(16'h120, 32'hB000_0000, 32'd16, 32'hD000_0200);
        poll_and_wait("R5");
        chk("R5", "two segments", 32'(seg_cnt), 32'd2);
        chk("R5", "past-wrap slot untouched", mem[72], 32'hB000_0000);
        chk("R4", "wrap flag kept", mem[68], 32'h3020_0000);
        put_desc(16'h100, 32'hB000_0000, 32'd16, 32'hD000_0300);
        poll_and_wait("R5");
        chk("R5", "resume at base", lg_addr[2], 32'hD000_0300);
    endtask

    // R8: stray descriptors flagged and skipped.
    task automatic t_orphan();
        do_reset();
        put_desc(16'h100, 32'hA000_0000, 32'd10, 32'hE000_0000);
        put_desc(16'h110, 32'hB000_0000, 32'd20, 32'hE000_0100);
        put_desc(16'h120, 32'h8000_0000, 32'd30, 32'hE000_0200);
        poll_and_wait("R8");
        chk("R8", "only valid segment", 32'(seg_cnt), 32'd1);
        chk("R8", "valid seg addr", lg_addr[0], 32'hE000_0100);
        chk("R8", "stray last wb", mem[64], 32'h2000_8000);
        chk("R8", "stray middle wb", mem[72], 32'h0000_8000);
        chk("R8", "error pulses", 32'(err_cnt), 32'd2);
        chk("R8", "good wb no error", mem[68], 32'h3000_0000);
    endtask

    // R7: raise and clear in the same cycle.
    task automatic t_collide();
        int wbn = 0;
        do_reset();
        put_desc(16'h100, 32'hF000_0000, 32'd4, 32'hF000_0000);
        put_desc(16'h110, 32'hF000_0000, 32'd4, 32'hF000_0100);
        @(negedge clk);
        poll_demand = 1'b1;
        @(negedge clk);
        poll_demand = 1'b0;
        for (int i = 0; i < 1000 && !suspended; i++) begin
            if (mem_we) begin
                wbn++;
                if (wbn == 2) irq_clr = 1'b1;
            end
            @(negedge clk);
            irq_clr = 1'b0;
        end
        chk("R7", "write-backs seen", 32'(wbn), 32'd2);
        chk("R7", "raise beats clear", 32'(tx_irq), 32'd1);
        pulse_clr();
        chk("R7", "lone clear", 32'(tx_irq), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL all watchdog expired: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_ring();
        t_orphan();
        t_collide();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule